// File: doc/BRIEF.md
# ATM Cell Delineation Engine

This block locates the 53-byte cell boundaries in a received ATM byte stream. It does this only by checking the header error control byte. While hunting, it tests a sliding five-byte window on every accepted byte. The first window whose fifth byte equals the check value of the four bytes before it fixes a tentative boundary. The engine then checks only the header slot of each later cell. It confirms the boundary after a run of good headers and gives it up after a run of bad ones.

Two 5-bit hysteresis thresholds come from a 16-bit configuration word and are sampled live. A loss threshold governs the synchronised state. A confirm threshold governs the pre-synchronised state. The outputs are three signals. A one-cycle strobe marks the first byte of each cell. A level reports that delineation is held. A one-cycle pulse fires whenever that level flips. Single-bit header correction, payload descrambling and storage belong to the blocks around it.

Top module: `atm_cell_delineator`

## Requirements
- R1: The check value is a CRC-8 over the four header bytes, with generator x^8+x^2+x+1, an all-zero start value, and the first byte fed most significant bit first. The result is XORed with 0x55. For example, header 00 00 00 01 carries check byte 0x52, and header 00 00 00 01 with check byte 0xAD is bad.
- R2: In the hunting state, each accepted byte from the fifth byte after reset onward completes a window made of the last five bytes. A matching window moves the engine to pre-sync and makes that byte the fifth byte of a cell. Leading bytes before the first cell are skipped this way.
- R3: In pre-sync, a single bad header returns the engine to hunting.
- R4: In pre-sync, a run of DELTA consecutive good headers moves the engine to sync. The header found while hunting does not count toward this run.
- R5: In sync, a run of ALPHA consecutive bad headers returns the engine to hunting. Any good header restarts the run.
- R6: ALPHA is cfg_i[4:0] and DELTA is cfg_i[9:5]. A threshold of zero acts as one. Bits 15:10 have no effect.
- R7: A cell is 53 bytes long, with the header check byte at offset 4. cell_start_o pulses for one cycle, one clock after the first byte of a cell is accepted. It pulses only in pre-sync or sync.
- R8: delin_o is 1 only in sync. It takes its new value one clock after the byte that decided the change.
- R9: delin_tgl_o is a one-cycle pulse in exactly the cycle in which delin_o changes value.
- R10: Cycles with rx_vld_i low change no state, no window content and no byte position.
- R11: Reset puts the engine in hunting, drives all outputs low and empties the window fill count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_byte_i | input | 8 | Received byte |
| rx_vld_i | input | 1 | rx_byte_i holds a byte this cycle |
| cfg_i | input | 16 | Threshold word: loss count [4:0], confirm count [9:5], [15:10] unused |
| cell_start_o | output | 1 | One-cycle strobe after the first byte of a cell |
| delin_o | output | 1 | Delineation held (sync state) |
| delin_tgl_o | output | 1 | One-cycle pulse when delin_o flips |

## Verification
The bench targets the off-by-one edges of both hysteresis counters. A design that counted the hunting match toward the confirm run would reach sync one cell early. A design that failed to restart the loss run on a good header would drop sync at the wrong cell. It also checks that a zero threshold behaves as one, since a naive compare would then never leave its state. It confirms that a single bad header in pre-sync drops the boundary, which is visible as a missing cell strobe. Leading junk bytes and idle gaps between bytes expose any design that advanced its window or position on invalid cycles, because the strobe and the sync point would then land on the wrong byte.

// File: rtl/cd_delin_pkg.sv
package cd_delin_pkg;

  typedef enum logic [1:0] {
    CD_HUNT = 2'd0,
    CD_PRE  = 2'd1,
    CD_SYNC = 2'd2
  } cd_state_e;

  localparam int unsigned HDR_BYTES = 4;
  localparam logic [7:0]  HEC_POLY  = 8'h07;
  localparam logic [7:0]  HEC_COSET = 8'h55;

  // Serial CRC-8, MSB first, zero start, coset added at the end
  function automatic logic [7:0] hec_of(input logic [8*HDR_BYTES-1:0] hdr);
    logic [7:0] crc;
    logic       fb;
    crc = 8'h00;
    for (int i = 8*HDR_BYTES-1; i >= 0; i--) begin
      fb  = crc[7] ^ hdr[i];
      crc = {crc[6:0], 1'b0} ^ (fb ? HEC_POLY : 8'h00);
    end
    return crc ^ HEC_COSET;
  endfunction

endpackage

// File: rtl/cd_hec_window.sv
module cd_hec_window
  import cd_delin_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vld_i,
  input  logic [7:0] byte_i,
  output logic       match_o
);
  localparam int unsigned WIN_W  = 8 * (HDR_BYTES + 1);
  localparam int unsigned FILL_W = $clog2(HDR_BYTES + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(HDR_BYTES);

  logic [WIN_W-1:0]  win_q, win_d;
  logic [FILL_W-1:0] fill_q;
  logic              win_full;

  assign win_d    = {win_q[WIN_W-9:0], byte_i};
  assign win_full = (fill_q == FILL_MAX);
  assign match_o  = vld_i && win_full && (hec_of(win_d[WIN_W-1:8]) == win_d[7:0]);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (vld_i) begin
      win_q <= win_d;
      if (!win_full) fill_q <= fill_q + 1'b1;
    end
  end

  AST_WIN_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> win_q[7:0] == $past(byte_i));  // R2
  AST_WIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(win_q) && $stable(fill_q));  // R10

endmodule

// File: rtl/cd_cell_pos.sv
module cd_cell_pos #(
  parameter int unsigned CELL_LEN = 53,
  parameter int unsigned HDR_POS  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic run_i,
  input  logic load_i,
  output logic hdr_slot_o,
  output logic start_slot_o
);
  localparam int unsigned POS_W = $clog2(CELL_LEN);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(CELL_LEN - 1);
  localparam logic [POS_W-1:0] POS_HDR  = POS_W'(HDR_POS);

  logic [POS_W-1:0] pos_q, pos_next;
  logic             step;

  assign step         = vld_i && run_i;
  assign pos_next     = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
  assign hdr_slot_o   = step && (pos_next == POS_HDR);
  assign start_slot_o = step && (pos_next == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     pos_q <= '0;
    else if (load_i) pos_q <= POS_HDR;
    else if (step)   pos_q <= pos_next;
  end

  AST_POS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= POS_LAST);  // R7
  AST_POS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(pos_q));  // R10

endmodule

// File: rtl/cd_fsm.sv
module cd_fsm
  import cd_delin_pkg::*;
#(
  parameter int unsigned THR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             match_i,
  input  logic             hdr_slot_i,
  input  logic             start_slot_i,
  input  logic [THR_W-1:0] alpha_i,
  input  logic [THR_W-1:0] delta_i,
  output logic             run_o,
  output logic             load_o,
  output logic             cell_start_o,
  output logic             delin_o,
  output logic             delin_tgl_o
);
  localparam int unsigned CNT_W = THR_W + 1;

  function automatic logic [CNT_W-1:0] thr_eff(input logic [THR_W-1:0] raw);
    return (raw == '0) ? CNT_W'(1) : {1'b0, raw};
  endfunction

  cd_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CNT_W-1:0] alpha_eff, delta_eff;
  logic             sync_d;

  assign alpha_eff = thr_eff(alpha_i);
  assign delta_eff = thr_eff(delta_i);
  assign cnt_inc   = cnt_q + 1'b1;
  assign run_o     = (state_q != CD_HUNT);
  assign load_o    = (state_q == CD_HUNT) && match_i;
  assign sync_d    = (state_d == CD_SYNC);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      CD_HUNT: if (match_i) begin
        state_d = CD_PRE;
        cnt_d   = '0;
      end
      CD_PRE: if (hdr_slot_i) begin
        if (!match_i) begin
          state_d = CD_HUNT;
          cnt_d   = '0;
        end else if (cnt_inc >= delta_eff) begin
          state_d = CD_SYNC;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      CD_SYNC: if (hdr_slot_i) begin
        if (match_i) begin
          cnt_d = '0;
        end else if (cnt_inc >= alpha_eff) begin
          state_d = CD_HUNT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: begin
        state_d = CD_HUNT;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q      <= CD_HUNT;
      cnt_q        <= '0;
      cell_start_o <= 1'b0;
      delin_o      <= 1'b0;
      delin_tgl_o  <= 1'b0;
    end else begin
      state_q      <= state_d;
      cnt_q        <= cnt_d;
      cell_start_o <= start_slot_i;
      delin_o      <= sync_d;
      delin_tgl_o  <= sync_d != (state_q == CD_SYNC);
    end
  end

  AST_HUNT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CD_HUNT) && match_i |=> state_q == CD_PRE);  // R2
  AST_PRE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CD_PRE) && hdr_slot_i && !match_i |=> state_q == CD_HUNT);  // R3
  AST_SYNC_GOOD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CD_SYNC) && hdr_slot_i && match_i |=> cnt_q == '0);  // R5
  AST_DELIN_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delin_o == (state_q == CD_SYNC));  // R8
  AST_TGL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delin_tgl_o == (delin_o != $past(delin_o)));  // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(state_q) && !cell_start_o);  // R10

endmodule

// File: rtl/atm_cell_delineator.sv
module atm_cell_delineator #(
  parameter int unsigned CELL_LEN = 53,
  parameter int unsigned THR_W    = 5,
  parameter int unsigned CFG_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       rx_byte_i,
  input  logic             rx_vld_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             cell_start_o,
  output logic             delin_o,
  output logic             delin_tgl_o
);
  localparam int unsigned ALPHA_LSB = 0;
  localparam int unsigned DELTA_LSB = THR_W;
  localparam int unsigned HDR_POS   = cd_delin_pkg::HDR_BYTES;

  logic match, hdr_slot, start_slot, run, load;
  logic unused_rsvd;

  assign unused_rsvd = ^cfg_i[CFG_W-1:2*THR_W];

  cd_hec_window u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (rx_vld_i),
    .byte_i  (rx_byte_i),
    .match_o (match)
  );

  cd_cell_pos #(.CELL_LEN(CELL_LEN), .HDR_POS(HDR_POS)) u_pos (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vld_i        (rx_vld_i),
    .run_i        (run),
    .load_i       (load),
    .hdr_slot_o   (hdr_slot),
    .start_slot_o (start_slot)
  );

  cd_fsm #(.THR_W(THR_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vld_i        (rx_vld_i),
    .match_i      (match),
    .hdr_slot_i   (hdr_slot),
    .start_slot_i (start_slot),
    .alpha_i      (cfg_i[ALPHA_LSB +: THR_W]),
    .delta_i      (cfg_i[DELTA_LSB +: THR_W]),
    .run_o        (run),
    .load_o       (load),
    .cell_start_o (cell_start_o),
    .delin_o      (delin_o),
    .delin_tgl_o  (delin_tgl_o)
  );

  AST_NO_START_IN_RESET: assert property (@(posedge clk_i)
    !rst_ni |=> !cell_start_o && !delin_o && !delin_tgl_o);  // R11

endmodule

// File: tb/atm_cell_delineator_tb_top.sv
module atm_cell_delineator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_vld = 1'b0;
  logic [15:0] cfg = '0;
  logic        cell_start, delin, tgl;

  int n_chk = 0;
  int n_fail = 0;
  int idx = 0;
  bit st_a [0:1023];
  bit dl_a [0:1023];
  bit tg_a [0:1023];

  always #4 clk = ~clk;

  atm_cell_delineator dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_byte_i(rx_byte), .rx_vld_i(rx_vld),
    .cfg_i(cfg), .cell_start_o(cell_start), .delin_o(delin), .delin_tgl_o(tgl)
  );

  // Remainder of header * x^8 by long division, then the coset
  function automatic logic [7:0] ref_hec(input logic [31:0] hdr);
    logic [39:0] r;
    r = {hdr, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0] ^ 8'h55;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] c);
    rx_vld = 1'b0;
    rst_n  = 1'b0;
    cfg    = c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idx   = 0;
    for (int i = 0; i < 1024; i++) begin
      st_a[i] = 1'b0; dl_a[i] = 1'b0; tg_a[i] = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    rx_byte = b;
    rx_vld  = 1'b1;
    @(negedge clk);
    st_a[idx] = cell_start;
    dl_a[idx] = delin;
    tg_a[idx] = tgl;
    idx++;
    rx_vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_cell(input bit good, input int gap);
    logic [7:0] h;
    h = ref_hec(32'h0000_0001);
    if (!good) h = h ^ 8'hFF;
    send_byte(8'h00, gap); send_byte(8'h00, gap);
    send_byte(8'h00, gap); send_byte(8'h01, gap);
    send_byte(h, gap);
    for (int i = 0; i < 48; i++) send_byte(8'h00, gap);
  endtask

  function automatic int count_tg();
    int n = 0;
    for (int i = 0; i < 1024; i++) n += int'(tg_a[i]);
    return n;
  endfunction

  function automatic int count_st();
    int n = 0;
    for (int i = 0; i < 1024; i++) n += int'(st_a[i]);
    return n;
  endfunction

  task automatic t_reset();
    do_reset(16'h0021);
    chk(!cell_start && !delin && !tgl, "R11 outputs low after reset", {cell_start, delin, tgl}, 0);
    send_cell(1, 0); send_cell(1, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!delin && !tgl && !cell_start, "R11 reset from sync", {cell_start, delin, tgl}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_basic_sync();
    do_reset(16'h0021);
    chk(ref_hec(32'h0000_0001) == 8'h52, "R1 idle header check byte", ref_hec(32'h1), 8'h52);
    for (int c = 0; c < 3; c++) send_cell(1, 0);
    chk(st_a[53], "R7 first boundary strobe", st_a[53], 1);
    chk(!dl_a[56] && dl_a[57], "R1 R4 sync after one confirming header", dl_a[57], 1);
    chk(tg_a[57] && count_tg() == 1, "R9 single toggle at sync", count_tg(), 1);
    chk(count_st() == 2, "R7 strobe once per cell", count_st(), 2);
  endtask

  task automatic t_delta3();
    do_reset(16'h0061);
    for (int c = 0; c < 5; c++) send_cell(1, 0);
    chk(!dl_a[162], "R4 hunting match not counted", dl_a[162], 0);
    chk(dl_a[163], "R4 sync after three good headers", dl_a[163], 1);
    chk(count_st() == 4, "R7 strobes across pre-sync and sync", count_st(), 4);
  endtask

  task automatic t_alpha3();
    bit pat [10] = '{1, 1, 0, 0, 1, 0, 0, 0, 1, 1};
    do_reset(16'h0023);
    for (int c = 0; c < 10; c++) send_cell(pat[c], 0);
    chk(dl_a[57], "R5 in sync", dl_a[57], 1);
    chk(dl_a[269], "R5 good header restarts run", dl_a[269], 1);
    chk(dl_a[370], "R5 still in sync after two bad", dl_a[370], 1);
    chk(!dl_a[375] && tg_a[375], "R5 R9 loss at third bad header", dl_a[375], 0);
    chk(!st_a[424], "R7 no strobe while hunting", st_a[424], 0);
    chk(st_a[477], "R2 boundary found again", st_a[477], 1);
    chk(dl_a[481], "R4 resync", dl_a[481], 1);
  endtask

  task automatic t_pre_drop();
    bit pat [5] = '{1, 0, 1, 1, 1};
    do_reset(16'h0041);
    for (int c = 0; c < 5; c++) send_cell(pat[c], 0);
    chk(st_a[53], "R7 pre-sync strobe", st_a[53], 1);
    chk(!st_a[106], "R3 bad header in pre-sync drops boundary", st_a[106], 0);
    chk(st_a[159], "R2 new boundary after drop", st_a[159], 1);
    chk(!dl_a[215] && dl_a[216], "R3 R4 sync only after two fresh good headers", dl_a[216], 1);
  endtask

  task automatic t_zero_thr();
    bit pat [4] = '{1, 1, 0, 1};
    do_reset(16'hFC00);
    for (int c = 0; c < 4; c++) send_cell(pat[c], 0);
    chk(dl_a[57], "R6 zero confirm count acts as one", dl_a[57], 1);
    chk(dl_a[109] && !dl_a[110], "R6 zero loss count acts as one", dl_a[110], 0);
    chk(count_tg() == 2, "R6 R9 reserved bits ignored, two toggles", count_tg(), 2);
  endtask

  task automatic t_gaps();
    do_reset(16'h0021);
    for (int i = 0; i < 7; i++) send_byte(8'h00, 2);
    for (int c = 0; c < 3; c++) send_cell(1, 2);
    chk(st_a[60], "R2 R10 boundary after leading junk and gaps", st_a[60], 1);
    chk(!dl_a[63] && dl_a[64], "R10 sync point unchanged by gaps", dl_a[64], 1);
    chk(count_tg() == 1, "R9 one toggle with gaps", count_tg(), 1);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_basic_sync();
        t_delta3();
        t_alpha3();
        t_pre_drop();
        t_zero_thr();
        t_gaps();
      end
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule